// File: doc/BRIEF.md
# Instruction Cache with Critical-First Line Refill

This block is a read-only instruction cache of 16 Kbytes. It is organised as 128 sets of four ways with 32-byte lines. Each line holds a tag and one valid bit. A fetch port takes a physical byte address. The cache accepts a request in the same cycle when it can serve it, and returns the 32-bit instruction word one cycle later. Instructions cannot be stored through the fetch port. Line contents change only when a refill writes them.

On a miss, the cache issues a single refill request, aligned to the missed 64-bit double word. Memory answers with four 64-bit beats. The first beat is the missed double word, and the rest follow in wrap order. The fetch port is held off only until that first beat arrives, and the beat is forwarded straight to the response. For the rest of the refill, the cache serves:

- fetches from other valid lines;
- fetches from double words of the incoming line that have already arrived;
- a fetch whose double word arrives in the same cycle.

A pulse on the flash-invalidate input clears every line in one cycle. Nothing snoops the cache, so software keeps it coherent through that input.

Top module: `fetch_cache`

## Requirements
- R1: Address fields are tag = addr[31:12], set = addr[11:5], double word = addr[4:3] and word = addr[2]. The response carries bits [63:32] of the double word when addr[2] is 1 and bits [31:0] when it is 0. Each set has four ways.
- R2: A request to a valid line raises `fetch_ready` in the same cycle. In the next cycle, `rsp_valid` is 1 and `rsp_data` holds the addressed word.
- R3: A request that misses while no refill is outstanding pulses `fill_req` for one cycle, with `fill_addr` equal to the address with bits [2:0] cleared, and keeps `fetch_ready` low.
- R4: Beats arrive in wrap order, starting with the missed double word. A fetch to the missed word is accepted in the cycle its beat arrives, and it returns that beat's data.
- R5: A fetch to the line being refilled is accepted if its double word has already arrived or arrives in the same cycle. Otherwise it stalls until that beat arrives.
- R6: Fetches that hit other valid lines are served while a refill is in progress.
- R7: A miss to a different line while a refill is outstanding raises neither `fill_req` nor `fetch_ready` until the last beat of that refill has arrived.
- R8: A line becomes valid only after all four beats have been written into it. The victim way is invalid from the moment its refill is requested.
- R9: While `flush_all` is high, no fetch is accepted. After a flush, every line is invalid and the refill in progress is no longer tracked, so its remaining beats are neither forwarded nor validated. No new refill starts until those remaining beats have drained.
- R10: The victim is the lowest-numbered invalid way of the set. When all four ways are valid, a three-bit tree pseudo-LRU per set picks the victim, and both hits and refills update it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_all | input | 1 | Flash-invalidate of every line |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | 32 | Physical byte address of the fetch |
| fetch_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Response word valid (one cycle after accept) |
| rsp_data | output | 32 | Instruction word |
| fill_req | output | 1 | Refill request pulse |
| fill_addr | output | 32 | Address of the missed double word |
| beat_valid | input | 1 | Refill beat present |
| beat_data | input | 64 | Refill beat data |

## Verification
The hardest situation to reach is a flash invalidate in the middle of a refill, followed by the remaining beats of the old burst. The bench starts a refill and lets the critical beat be forwarded, then pulses `flush_all`. It then sends the three remaining beats while it holds fetches to both the aborted line and a previously valid line. Those fetches must stay stalled, and no refill may be requested. Afterwards, both lines must miss again. The pseudo-LRU order is reached by filling all four ways of one set, touching one way, and checking which line a fifth refill evicts.

// File: rtl/fetch_cache.sv
module fetch_cache #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_all,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              beat_valid,
  input  logic [63:0]       beat_data
);
  localparam int WAYS   = 4;
  localparam int BEATS  = 4;
  localparam int OFF_W  = 5;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = ADDR_W - OFF_W;

  logic [TAG_W-1:0]      tag_mem  [SETS*WAYS];
  logic [63:0]           data_mem [SETS*WAYS*BEATS];
  logic [2:0]            plru_q   [SETS];
  logic [SETS*WAYS-1:0]  valid_q;

  logic              busy_q, track_q;
  logic [1:0]        got_q, crit_q, way_q;
  logic [3:0]        mask_q;
  logic [LINE_W-1:0] line_q;
  logic [63:0]       rd_q;
  logic              word_q, rsp_q;

  wire [IDX_W-1:0]  idx   = fetch_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  tag   = fetch_addr[ADDR_W-1 -: TAG_W];
  wire [1:0]        dw    = fetch_addr[4:3];
  wire [LINE_W-1:0] fline = fetch_addr[ADDR_W-1:OFF_W];

  logic unused_lsb;
  assign unused_lsb = ^fetch_addr[1:0];

  logic [WAYS-1:0] hit_vec;
  logic [1:0]      hit_way, victim;
  logic            hit;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = valid_q[{idx, 2'(w)}] && (tag_mem[{idx, 2'(w)}] == tag);
      if (hit_vec[w]) hit_way = 2'(w);
    end
    hit = |hit_vec;
  end

  always_comb begin
    logic [2:0] p;
    p = plru_q[idx];
    victim = p[0] ? {1'b1, p[2]} : {1'b0, p[1]};
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_q[{idx, 2'(w)}]) victim = 2'(w);
  end

  function automatic logic [2:0] touch(input logic [2:0] p, input logic [1:0] w);
    logic [2:0] n;
    n = p;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0];
    else      n[1] = ~w[0];
    return n;
  endfunction

  wire [1:0] cur_dw    = crit_q + got_q;
  wire       beat_in   = beat_valid && busy_q;
  wire       beat_wr   = beat_in && track_q;
  wire       last_beat = beat_in && (got_q == 2'd3);
  wire       in_flight = track_q && (line_q == fline);
  wire       fwd       = in_flight && beat_wr && (cur_dw == dw);
  wire       part_ok   = in_flight && (mask_q[dw] || fwd);
  wire [1:0] rd_way    = in_flight ? way_q : hit_way;

  assign fetch_ready = fetch_req && !flush_all && (hit || part_ok);
  assign fill_req    = fetch_req && !flush_all && !hit && !in_flight && !busy_q;
  assign fill_addr   = {fetch_addr[ADDR_W-1:3], 3'b000};
  assign rsp_valid   = rsp_q;
  assign rsp_data    = word_q ? rd_q[63:32] : rd_q[31:0];

  always_ff @(posedge clk) begin
    if (beat_wr) data_mem[{line_q[IDX_W-1:0], way_q, cur_dw}] <= beat_data;
    if (fill_req) tag_mem[{idx, victim}] <= tag;
    if (fetch_ready) begin
      rd_q   <= fwd ? beat_data : data_mem[{idx, rd_way, dw}];
      word_q <= fetch_addr[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      busy_q  <= 1'b0;
      track_q <= 1'b0;
      got_q   <= '0;
      crit_q  <= '0;
      way_q   <= '0;
      mask_q  <= '0;
      line_q  <= '0;
      rsp_q   <= 1'b0;
      for (int s = 0; s < SETS; s++) plru_q[s] <= '0;
    end else begin
      rsp_q <= fetch_ready;
      if (beat_in) begin
        got_q <= got_q + 2'd1;
        if (last_beat) busy_q <= 1'b0;
      end
      if (beat_wr) mask_q[cur_dw] <= 1'b1;
      if (beat_wr && last_beat) begin
        valid_q[{line_q[IDX_W-1:0], way_q}] <= 1'b1;
        track_q <= 1'b0;
        mask_q  <= '0;
      end
      if (fill_req) begin
        busy_q  <= 1'b1;
        track_q <= 1'b1;
        got_q   <= '0;
        crit_q  <= dw;
        line_q  <= fline;
        way_q   <= victim;
        mask_q  <= '0;
        valid_q[{idx, victim}] <= 1'b0;
        plru_q[idx] <= touch(plru_q[idx], victim);
      end else if (fetch_ready && hit) begin
        plru_q[idx] <= touch(plru_q[idx], hit_way);
      end
      if (flush_all) begin
        valid_q <= '0;
        track_q <= 1'b0;
        mask_q  <= '0;
      end
    end
  end

  p_single_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |=> !fill_req);

  p_fill_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !fetch_ready);

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0));

  p_victim_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |=> !valid_q[$past({idx, victim})]);

  p_crit_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_wr && got_q == 2'd0 && fetch_req && !flush_all && in_flight && dw == crit_q)
      |-> fetch_ready);

  p_rsp_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(fetch_req));
endmodule

// File: tb/fetch_cache_bench.sv
module fetch_cache_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_all = 1'b0;
  logic        fetch_req = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        beat_valid = 1'b0;
  logic [63:0] beat_data = '0;
  logic        fetch_ready, rsp_valid, fill_req;
  logic [31:0] rsp_data, fill_addr;

  int n_chk = 0;
  int n_fail = 0;

  fetch_cache u_fetch_cache (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .fill_req(fill_req), .fill_addr(fill_addr),
    .beat_valid(beat_valid), .beat_data(beat_data)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] wv(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic [63:0] bt(input logic [31:0] base, input logic [1:0] d);
    logic [31:0] lo;
    lo = {base[31:5], 5'b0} + {27'd0, d, 3'b000};
    return {wv(lo + 32'd4), wv(lo)};
  endfunction

  task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic drive(input logic rq, input logic [31:0] a, input logic bv,
                       input logic [63:0] bd, input logic fl);
    fetch_req = rq; fetch_addr = a; beat_valid = bv; beat_data = bd; flush_all = fl;
    #1;
  endtask

  task automatic next();
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1'b0, 32'h0, 1'b0, 64'h0, 1'b0);
  endtask

  task automatic beats(input logic [31:0] base, input logic [1:0] crit);
    for (int i = 0; i < 4; i++) begin
      drive(1'b0, 32'h0, 1'b1, bt(base, crit + 2'(i)), 1'b0);
      next();
    end
    idle();
  endtask

  task automatic hit_fetch(input string r, input logic [31:0] a);
    drive(1'b1, a, 1'b0, 64'h0, 1'b0);
    chk(r, "hit ready", fetch_ready, 1);
    chk(r, "hit no fill", fill_req, 0);
    next();
    idle();
    chk(r, "rsp_valid", rsp_valid, 1);
    chk(r, "rsp_data", rsp_data, wv(a));
  endtask

  task automatic fill(input string r, input logic [31:0] a);
    drive(1'b1, a, 1'b0, 64'h0, 1'b0);
    chk(r, "fill_req", fill_req, 1);
    chk(r, "fill_addr", fill_addr, {a[31:3], 3'b000});
    chk(r, "miss ready", fetch_ready, 0);
    next();
    beats(a, a[4:3]);
  endtask

  task automatic t_reset();
    idle();
    chk("R2", "reset rsp_valid", rsp_valid, 0);
    chk("R3", "reset fill_req", fill_req, 0);
    chk("R2", "reset ready", fetch_ready, 0);
  endtask

  task automatic t_crit();
    logic [31:0] a = 32'h1000_0014;
    drive(1'b1, a, 1'b0, 64'h0, 1'b0);
    chk("R3", "fill_req", fill_req, 1);
    chk("R3", "fill_addr", fill_addr, 32'h1000_0010);
    chk("R3", "ready on miss", fetch_ready, 0);
    next();
    drive(1'b1, a, 1'b0, 64'h0, 1'b0);
    chk("R3", "stall before beat", fetch_ready, 0);
    chk("R3", "single fill_req", fill_req, 0);
    next();
    drive(1'b1, a, 1'b1, bt(a, 2'd2), 1'b0);
    chk("R4", "ready with critical beat", fetch_ready, 1);
    next();
    drive(1'b0, 32'h0, 1'b1, bt(a, 2'd3), 1'b0);
    chk("R4", "fwd rsp_valid", rsp_valid, 1);
    chk("R1", "fwd upper word", rsp_data, wv(a));
    next();
    drive(1'b0, 32'h0, 1'b1, bt(a, 2'd0), 1'b0);
    next();
    drive(1'b0, 32'h0, 1'b1, bt(a, 2'd1), 1'b0);
    next();
    idle();
    hit_fetch("R4", 32'h1000_0000);
    hit_fetch("R4", 32'h1000_0018);
    hit_fetch("R2", 32'h1000_000C);
  endtask

  task automatic t_inflight();
    logic [31:0] b = 32'h2000_0040;
    drive(1'b1, b, 1'b0, 64'h0, 1'b0);
    chk("R3", "fill_req B", fill_req, 1);
    next();
    drive(1'b1, b, 1'b1, bt(b, 2'd0), 1'b0);
    chk("R4", "crit B ready", fetch_ready, 1);
    next();
    drive(1'b1, b + 32'h18, 1'b0, 64'h0, 1'b0);
    chk("R4", "crit B data", rsp_data, wv(b));
    chk("R5", "missing beat stalls", fetch_ready, 0);
    next();
    drive(1'b1, b + 32'h18, 1'b1, bt(b, 2'd1), 1'b0);
    chk("R5", "other beat does not release", fetch_ready, 0);
    next();
    drive(1'b1, b + 32'h4, 1'b0, 64'h0, 1'b0);
    chk("R5", "received beat ready", fetch_ready, 1);
    next();
    drive(1'b1, b + 32'hC, 1'b0, 64'h0, 1'b0);
    chk("R5", "received beat data", rsp_data, wv(b + 32'h4));
    chk("R5", "stored beat ready", fetch_ready, 1);
    next();
    drive(1'b1, 32'h1000_0008, 1'b0, 64'h0, 1'b0);
    chk("R5", "stored beat data", rsp_data, wv(b + 32'hC));
    chk("R6", "other line hit during fill", fetch_ready, 1);
    next();
    drive(1'b1, 32'h3000_0000, 1'b0, 64'h0, 1'b0);
    chk("R6", "other line data", rsp_data, wv(32'h1000_0008));
    chk("R7", "second miss stalls", fetch_ready, 0);
    chk("R7", "no second fill_req", fill_req, 0);
    next();
    drive(1'b1, 32'h3000_0000, 1'b1, bt(b, 2'd2), 1'b0);
    chk("R7", "still no fill_req", fill_req, 0);
    next();
    drive(1'b1, b + 32'h1C, 1'b1, bt(b, 2'd3), 1'b0);
    chk("R5", "ready as beat arrives", fetch_ready, 1);
    next();
    drive(1'b1, 32'h3000_0000, 1'b0, 64'h0, 1'b0);
    chk("R5", "forwarded last beat", rsp_data, wv(b + 32'h1C));
    chk("R7", "fill_req after completion", fill_req, 1);
    next();
    beats(32'h3000_0000, 2'd0);
    hit_fetch("R8", b + 32'h10);
    hit_fetch("R2", 32'h3000_0004);
  endtask

  task automatic t_flush();
    logic [31:0] a = 32'h4000_0028;
    drive(1'b1, a, 1'b0, 64'h0, 1'b0);
    chk("R3", "fill_req C", fill_req, 1);
    next();
    drive(1'b1, a, 1'b1, bt(a, 2'd1), 1'b0);
    chk("R4", "crit C ready", fetch_ready, 1);
    next();
    drive(1'b1, 32'h1000_0000, 1'b0, 64'h0, 1'b1);
    chk("R9", "no accept during flush", fetch_ready, 0);
    chk("R4", "crit C data", rsp_data, wv(a));
    next();
    drive(1'b1, 32'h1000_0000, 1'b0, 64'h0, 1'b0);
    chk("R9", "flushed line stalls while draining", fetch_ready, 0);
    chk("R9", "no fill while draining", fill_req, 0);
    next();
    drive(1'b1, a, 1'b1, bt(a, 2'd2), 1'b0);
    chk("R9", "aborted line not forwarded", fetch_ready, 0);
    next();
    drive(1'b1, a + 32'h8, 1'b1, bt(a, 2'd3), 1'b0);
    chk("R9", "aborted beat ignored", fetch_ready, 0);
    next();
    drive(1'b1, a, 1'b1, bt(a, 2'd0), 1'b0);
    chk("R9", "last drain beat ignored", fetch_ready, 0);
    next();
    drive(1'b1, a, 1'b0, 64'h0, 1'b0);
    chk("R8", "aborted line never valid", fill_req, 1);
    chk("R8", "aborted line no hit", fetch_ready, 0);
    next();
    beats(a, 2'd1);
    hit_fetch("R8", a);
    fill("R9", 32'h1000_0000);
    hit_fetch("R9", 32'h1000_0004);
  endtask

  function automatic logic [31:0] pa(input int k);
    return ((32'h50 + 32'(k)) << 12) | 32'h200;
  endfunction

  task automatic t_plru();
    // R1: all addresses share set 16 (addr[11:5]) and differ in tag
    for (int k = 0; k < 4; k++) fill("R10", pa(k));
    for (int k = 0; k < 4; k++) hit_fetch("R1", pa(k) + 32'h4);
    hit_fetch("R10", pa(1));
    fill("R10", pa(4));
    hit_fetch("R10", pa(0));
    hit_fetch("R10", pa(1));
    hit_fetch("R10", pa(3));
    hit_fetch("R10", pa(4));
    drive(1'b1, pa(2), 1'b0, 64'h0, 1'b0);
    chk("R10", "way 2 was the victim", fill_req, 1);
    next();
    beats(pa(2), 2'd0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    next();
    next();
    rst_n = 1'b1;
    next();
    t_reset();
    t_crit();
    t_inflight();
    t_flush();
    t_plru();
    next();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule